// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block gathers one-clock interrupt pulses from a fixed set of sources and holds each in a sticky pending bit. Every source has a 2-bit priority field. A value of zero switches the source off. Values one to three place it on a level, and three is the highest level. A combinational arbiter picks the winning pending and enabled source. It looks at the highest occupied level first and then at the lowest source index within that level. A small set of critical sources, chosen by a parameter, is lifted to the top level whenever it is enabled.

A global enable gates the request to the CPU. Software sets and clears the enable through a register port. Every acknowledge clears it, and so do a disable input and a trap-event input. When the enable is set and a winner exists, the block registers the winner's index as the vector and raises the CPU request. It holds both until the CPU acknowledges. The acknowledge clears the pending bit of the vector that was presented. Software can also clear pending bits directly, by writing zero to them.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A pending enabled source on a higher effective level always wins over any source on a lower level.
- R2: Among pending enabled sources on the same level, the lowest source index wins.
- R3: A source marked critical (default: sources 6 and 7) with a nonzero priority field is treated as level 3, whatever value the field holds.
- R4: A one-cycle pulse on `src_pulse[i]` sets pending bit i on the next clock edge, and the bit stays set. Pending bits read back at register address 0, bit i for source i.
- R5: An acknowledge clears the pending bit of the source whose index is on `irq_vec`.
- R6: A write to address 0 clears every pending bit written as 0 and leaves every bit written as 1 unchanged. A source pulse in the same cycle as a clearing write leaves its bit set.
- R7: Writing 1 to bit 0 of address 2 sets the global enable, and writing 0 there clears it. The enable reads back at the same bit.
- R8: The global enable is cleared on the edge after an acknowledge, after `di_req`, or after `trap_evt`. A clear from any of these wins over a software set in the same cycle.
- R9: `irq_req` rises only when the global enable is 1 and some source is both pending and enabled. A source with priority field 0 (bits 2i+1:2i of address 1) stays pending but never raises a request.
- R10: `irq_vec` and `irq_req` are registered. Once `irq_req` is high, both hold steady until the cycle in which `irq_ack` is taken.
- R11: After reset, all pending bits, all priority fields, the global enable and `irq_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_pulse | input | NUM_SRC | One-cycle interrupt pulses, one per source |
| trap_evt | input | 1 | Trap event; clears the global enable |
| di_req | input | 1 | Disable-interrupt request; clears the global enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pending, 1 priorities, 2 control |
| reg_wdata | input | 2*NUM_SRC | Register write data |
| reg_rdata | output | 2*NUM_SRC | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_vec | output | $clog2(NUM_SRC) | Index of the winning source |

## Verification
A wrong pending bit shows up at register address 0 one edge after the pulse or the write that caused it. At the CPU side it appears as a wrong or extra vector two edges after the pulse. A faulty arbiter or wrong level mapping shows up as a vector that breaks the expected order the first time two sources compete. A global enable that fails to clear shows up as a second request straight after an acknowledge, or as a 1 at address 2. A vector that drifts while a request is held is caught one cycle later by comparing the value seen on two successive cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    LVL_OFF = 2'd0,
    LVL_LOW = 2'd1,
    LVL_MID = 2'd2,
    LVL_TOP = 2'd3
  } lvl_e;

  localparam logic [1:0] ADDR_PEND = 2'd0;
  localparam logic [1:0] ADDR_PRIO = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int NUM_SRC = 8,
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_data,
  input  logic               ack_take,
  input  logic [IW-1:0]      ack_idx,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] pend_q, pend_d, ack_mask;
  logic               pend_en;

  always_comb begin
    ack_mask = '0;
    if (ack_take) ack_mask[ack_idx] = 1'b1;
    pend_d = pend_q & ~ack_mask;
    if (clr_wr) pend_d = pend_d & clr_data;
    pend_d = pend_d | src_pulse;
    pend_en = (|src_pulse) | clr_wr | ack_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend = pend_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    assert_pulse_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      src_pulse[i] |=> pend_q[i]);
    assert_write_one_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && clr_wr && clr_data[i] && !(ack_take && ack_idx == IW'(i))) |=> pend_q[i]);
  end
endmodule

// File: rtl/irqc_gie.sv
module irqc_gie (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wr,
  input  logic wr_val,
  input  logic di_req,
  input  logic trap_evt,
  input  logic ack_take,
  output logic gie
);
  logic gie_q, gie_d, gie_en, kill;

  always_comb begin
    kill   = di_req | trap_evt | ack_take;
    gie_en = kill | set_wr;
    gie_d  = kill ? 1'b0 : wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else if (gie_en) gie_q <= gie_d;
  end

  assign gie = gie_q;

  assert_kill_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (di_req || trap_evt || ack_take) |=> !gie_q);
  assert_sw_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && wr_val && !di_req && !trap_evt && !ack_take) |=> gie_q);
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int                NUM_SRC   = 8,
  parameter logic [NUM_SRC-1:0] CRIT_MASK = 8'hC0,
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [2*NUM_SRC-1:0] prio,
  input  logic [NUM_SRC-1:0]   pend,
  output logic [NUM_SRC-1:0]   act,
  output logic                 any,
  output logic [IW-1:0]        win
);
  lvl_e               eff [NUM_SRC];
  logic [NUM_SRC-1:0] hit [4];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [1:0] fld;
    assign fld    = prio[2*i +: 2];
    assign eff[i] = (CRIT_MASK[i] && fld != 2'd0) ? LVL_TOP : lvl_e'(fld);
    assign act[i] = pend[i] && (fld != 2'd0);
    for (genvar l = 0; l < 4; l++) begin : g_lvl
      assign hit[l][i] = act[i] && (eff[i] == lvl_e'(l));
    end
  end

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int l = 3; l >= 1; l--) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (!any && hit[l][i]) begin
          any = 1'b1;
          win = IW'(i);
        end
      end
    end
  end

  always_comb begin
    if (any) assert_win_active_R2: assert (act[win]);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int                 NUM_SRC   = 8,
  parameter logic [NUM_SRC-1:0] CRIT_MASK = 8'hC0,
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int DW = 2 * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               trap_evt,
  input  logic               di_req,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq_req,
  input  logic               irq_ack,
  output logic [IW-1:0]      irq_vec
);
  logic [1:0]         rst_sync;
  logic               rst_i_n;
  logic [DW-1:0]      prio_q;
  logic [NUM_SRC-1:0] pend, act;
  logic               gie, any, ack_take;
  logic [IW-1:0]      win;
  logic               wr_pend, wr_prio, wr_ctrl;
  logic               req_q, req_d, irq_en;
  logic [IW-1:0]      vec_q, vec_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign wr_pend  = reg_wr && reg_addr == ADDR_PEND;
  assign wr_prio  = reg_wr && reg_addr == ADDR_PRIO;
  assign wr_ctrl  = reg_wr && reg_addr == ADDR_CTRL;
  assign ack_take = irq_ack && req_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) prio_q <= '0;
    else if (wr_prio) prio_q <= reg_wdata;
  end

  irqc_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_i_n), .src_pulse(src_pulse),
    .clr_wr(wr_pend), .clr_data(reg_wdata[NUM_SRC-1:0]),
    .ack_take(ack_take), .ack_idx(vec_q), .pend(pend)
  );

  irqc_gie u_gie (
    .clk(clk), .rst_n(rst_i_n), .set_wr(wr_ctrl), .wr_val(reg_wdata[0]),
    .di_req(di_req), .trap_evt(trap_evt), .ack_take(ack_take), .gie(gie)
  );

  irqc_arb #(.NUM_SRC(NUM_SRC), .CRIT_MASK(CRIT_MASK)) u_arb (
    .prio(prio_q), .pend(pend), .act(act), .any(any), .win(win)
  );

  always_comb begin
    irq_en = !req_q || ack_take;
    req_d  = gie && any && !req_q;
    vec_d  = req_q ? vec_q : win;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else if (irq_en) begin
      req_q <= req_d;
      vec_q <= vec_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_PEND: reg_rdata[NUM_SRC-1:0] = pend;
      ADDR_PRIO: reg_rdata = prio_q;
      ADDR_CTRL: reg_rdata[0] = gie;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_q && !irq_ack) |=> (req_q && $stable(vec_q)));
  assert_gated_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(req_q) |-> ($past(gie) && act[vec_q]));
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ack_take && !src_pulse[vec_q]) |=> !pend[$past(vec_q)]);
  assert_ack_drops_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    ack_take |=> !req_q);
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_pulse = '0;
  logic          trap_evt = 1'b0, di_req = 1'b0, reg_wr = 1'b0, irq_ack = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_req;
  logic [IW-1:0] irq_vec;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .trap_evt(trap_evt),
    .di_req(di_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    src_pulse = m;
    @(negedge clk);
    src_pulse = '0;
  endtask

  // driver: push expected vector, open the global enable, wait for the monitor
  task automatic serve(input int v, input string tag);
    exp_q.push_back(v);
    wr(2'd2, 16'h1);
    for (int k = 0; k < 20 && exp_q.size() != 0; k++) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL %s: no request, actual none expected vector %0d", tag, v);
      exp_q.delete();
    end
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare each presented vector, check it holds, then acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (irq_req && !done) begin
        int seen, e;
        seen = int'(irq_vec);
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9: unexpected request, actual vector %0d expected none", seen);
        end else begin
          e = exp_q.pop_front();
          check("R1/R2/R3 vector", seen, e);
        end
        @(negedge clk);
        check("R10 request held", int'(irq_req), 1);
        check("R10 vector stable", int'(irq_vec), seen);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R10 request dropped after ack", int'(irq_req), 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(2'd0, v); check("R11 pending", v, 0);
    rd(2'd1, v); check("R11 priorities", v, 0);
    rd(2'd2, v); check("R11 global enable", v, 0);
    check("R11 irq_req", int'(irq_req), 0);

    // R1 R2 R4 R5: src1=2, src2=2, src4=3
    wr(2'd1, 16'h0328);
    pulse(8'h16);
    rd(2'd0, v); check("R4 sticky capture", v, 'h16);
    serve(4, "R1");
    rd(2'd2, v); check("R8 ack clears enable", v, 0);
    rd(2'd0, v); check("R5 ack clears bit 4", v, 'h06);
    serve(1, "R2");
    serve(2, "R2");
    rd(2'd0, v); check("R5 all drained", v, 0);

    // R3: critical src7 at programmed level 1 beats src3 at level 2
    wr(2'd1, 16'h4080);
    pulse(8'h88);
    serve(7, "R3");
    serve(3, "R3");

    // R9: priority 0 keeps source pending but silent
    wr(2'd1, 16'h0300);
    pulse(8'h20);
    wr(2'd2, 16'h1);
    rd(2'd2, v); check("R7 enable set", v, 1);
    repeat (5) @(negedge clk);
    check("R9 disabled source no request", int'(irq_req), 0);
    rd(2'd0, v); check("R9 disabled source pending", v, 'h20);
    wr(2'd2, 16'h0);
    rd(2'd2, v); check("R7 enable cleared", v, 0);

    // R6 write-0 clears, write-1 keeps
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); check("R6 write one keeps", v, 'h20);
    wr(2'd0, 16'hFFDF);
    rd(2'd0, v); check("R6 write zero clears", v, 0);

    // R6 pulse wins over clearing write in same cycle
    @(negedge clk);
    src_pulse = 8'h01; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0000;
    @(negedge clk);
    src_pulse = '0; reg_wr = 1'b0;
    rd(2'd0, v); check("R6 pulse beats clear", v, 'h01);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R6 cleared", v, 0);

    // R8 disable input and trap input
    wr(2'd2, 16'h1);
    @(negedge clk); di_req = 1'b1; @(negedge clk); di_req = 1'b0;
    rd(2'd2, v); check("R8 di clears enable", v, 0);
    wr(2'd2, 16'h1);
    @(negedge clk); trap_evt = 1'b1; @(negedge clk); trap_evt = 1'b0;
    rd(2'd2, v); check("R8 trap clears enable", v, 0);
    @(negedge clk);
    trap_evt = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h1;
    @(negedge clk);
    trap_evt = 1'b0; reg_wr = 1'b0;
    rd(2'd2, v); check("R8 trap beats set", v, 0);

    // R9: enabled pending with global enable off stays silent
    pulse(8'h10);
    repeat (5) @(negedge clk);
    check("R9 no request with enable off", int'(irq_req), 0);
    serve(4, "R9");

    done = 1;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule